// File: doc/BRIEF.md
# Gray-Level Palette and Pixel Mapper

This block converts packed display memory bytes into the actual gray level a segment driver needs. A CPU-side write port reaches two registers: an 8-bit control register and one shared palette address. Behind the palette address are sixteen 5-bit mapping entries. Each entry selects one of 32 real gray levels. A write pointer steps through the entries on every palette write, so software loads the whole table by writing to the same address sixteen times. A control write with the pointer-restart bit (bit 5) cleared sends the pointer back to entry 0.

On the display side, the block takes one memory byte, a pixel-depth mode and a pixel index within that byte. It unpacks the pixel code and looks it up in the table, or passes it through directly in black/white mode. The resulting 5-bit level appears on a registered output one clock later. The display timing, waveform generation and the display memory itself sit outside this block.

Top module: `gray_palette_mapper`

## Requirements
- R1: After reset, entry i holds 2*i (0x00, 0x02 … 0x1E), the write pointer is at entry 0, the control register reads 0x00 and `gray_out` is 0.
- R2: A palette write (`cfg_we`=1, `cfg_sel`=1) loads the entry under the pointer and then moves the pointer to the next entry. The first write after reset lands in entry 0.
- R3: After the write to entry 15, the pointer wraps to entry 0.
- R4: A control write (`cfg_we`=1, `cfg_sel`=0) with bit 5 of the data at 0 returns the pointer to entry 0. A control write with bit 5 at 1 leaves the pointer where it is.
- R5: The control register stores all 8 written bits and shows them on `ctrl_rdata`.
- R6: A palette write stores only data bits 4:0; bits 7:5 have no effect on the stored entry.
- R7: In 16-gray mode (`pix_mode`=2'b10), `pix_idx[0]`=0 selects code bits 3:0 and `pix_idx[0]`=1 selects bits 7:4. The 4-bit code indexes all sixteen entries. `pix_idx[2:1]` is ignored.
- R8: In 4-gray mode (`pix_mode`=2'b01), `pix_idx[1:0]`=k selects byte bits 2k+1:2k as the code, and only entries 0–3 are reached. `pix_idx[2]` is ignored.
- R9: In black/white mode (`pix_mode`=2'b00), byte bit `pix_idx` selects the output directly, bypassing the table: a 0 gives level 0 and a 1 gives level 31.
- R10: `gray_out` shows the lookup of the inputs present one clock edge earlier. A palette write in the same cycle as a lookup of that entry gives the old entry value.
- R11: Mode code 2'b11 behaves exactly as 16-gray mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 = control register, 1 = shared palette address |
| cfg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register contents |
| pix_byte | input | 8 | Packed display memory byte |
| pix_mode | input | 2 | 00 black/white, 01 4-gray, 10/11 16-gray |
| pix_idx | input | 3 | Pixel index within the byte |
| gray_out | output | 5 | Registered actual gray level |

## Verification
The bench goes after four corner cases.

- **Pointer wrap on the seventeenth write.** The extra write must land in entry 0. A pointer that saturates at entry 15 would instead overwrite entry 15.
- **Control writes with bit 5 set and with bit 5 clear.** A design that restarts the pointer on any control write would send the next palette write to entry 0 when it should go to the following entry.
- **Index bits that each mode must ignore.** A design that uses them would pick the wrong nibble or pair.
- **Palette write and lookup of the same entry in one cycle.** The output must show the old value; a write-through path would show the new one a cycle early.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

  typedef enum logic [1:0] {
    MODE_BW   = 2'b00,
    MODE_G4   = 2'b01,
    MODE_G16  = 2'b10,
    MODE_G16X = 2'b11
  } pix_mode_e;

  // reset content of a palette entry: an even ramp over the level range
  function automatic logic [4:0] entry_reset(input int unsigned i);
    return 5'(2 * i);
  endfunction

  // 4-bit code of a 16-gray pixel: idx 0 is the low nibble
  function automatic logic [3:0] code_g16(input logic [7:0] b, input logic [2:0] idx);
    return idx[0] ? b[7:4] : b[3:0];
  endfunction

  // 2-bit code of a 4-gray pixel: idx k takes bits 2k+1:2k
  function automatic logic [1:0] code_g4(input logic [7:0] b, input logic [2:0] idx);
    logic [7:0] sh;
    sh = b >> {idx[1:0], 1'b0};
    return sh[1:0];
  endfunction

  // one bit of a black/white pixel
  function automatic logic bit_bw(input logic [7:0] b, input logic [2:0] idx);
    return b[idx];
  endfunction

endpackage

// File: rtl/gpm_ctrl.sv
module gpm_ctrl #(
  parameter int DATA_W      = 8,
  parameter int PTR_RST_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              ptr_clr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  // restart request: any control write leaving the restart bit low
  assign ptr_clr = ctrl_wr && !wdata[PTR_RST_BIT];

endmodule

// File: rtl/gpm_palette.sv
module gpm_palette #(
  parameter int ENTRIES = 16,
  parameter int LVL_W   = 5,
  parameter int DATA_W  = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     ptr_clr,
  input  logic [PTR_W-1:0]         rd_idx,
  output logic [LVL_W-1:0]         rd_lvl,
  output logic [PTR_W-1:0]         wr_ptr,
  output logic [ENTRIES*LVL_W-1:0] flat
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [LVL_W-1:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent[g] <= LVL_W'(gpm_pkg::entry_reset(g));
      else if (wr_en && wr_ptr == PTR_W'(g)) ent[g] <= wr_data[LVL_W-1:0];
    end
    assign flat[g*LVL_W +: LVL_W] = ent[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= '0;
    else if (ptr_clr) wr_ptr <= '0;
    else if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  end

  assign rd_lvl = ent[rd_idx];

endmodule

// File: rtl/gpm_unpack.sv
module gpm_unpack #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic [1:0]        mode,
  input  logic [2:0]        idx,
  output logic [CODE_W-1:0] code,
  output logic              is_bw,
  output logic              bw_bit
);
  import gpm_pkg::*;

  always_comb begin
    is_bw  = 1'b0;
    bw_bit = bit_bw(byte_in, idx);
    code   = '0;
    unique case (pix_mode_e'(mode))
      MODE_BW:            is_bw = 1'b1;
      MODE_G4:            code  = CODE_W'(code_g4(byte_in, idx));
      MODE_G16, MODE_G16X: code = CODE_W'(code_g16(byte_in, idx));
      default:            code  = '0;
    endcase
  end

endmodule

// File: rtl/gray_palette_mapper.sv
module gray_palette_mapper #(
  parameter int ENTRIES     = 16,
  parameter int LVL_W       = 5,
  parameter int DATA_W      = 8,
  parameter int PTR_RST_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] ctrl_rdata,
  input  logic [DATA_W-1:0] pix_byte,
  input  logic [1:0]        pix_mode,
  input  logic [2:0]        pix_idx,
  output logic [LVL_W-1:0]  gray_out
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  // named internal events for the checker
  logic                     pal_wr;
  logic                     ctrl_wr;
  logic                     ptr_clr;
  logic [PTR_W-1:0]         wr_ptr;
  logic [ENTRIES*LVL_W-1:0] pal_flat;
  logic [PTR_W-1:0]         code;
  logic                     is_bw;
  logic                     bw_bit;
  logic [LVL_W-1:0]         pal_lvl;
  logic [LVL_W-1:0]         lvl_next;

  assign pal_wr  = cfg_we &&  cfg_sel;
  assign ctrl_wr = cfg_we && !cfg_sel;

  gpm_ctrl #(.DATA_W(DATA_W), .PTR_RST_BIT(PTR_RST_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(cfg_wdata),
    .ctrl_q(ctrl_rdata), .ptr_clr(ptr_clr)
  );

  gpm_palette #(.ENTRIES(ENTRIES), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_pal (
    .clk(clk), .rst_n(rst_n), .wr_en(pal_wr), .wr_data(cfg_wdata),
    .ptr_clr(ptr_clr), .rd_idx(code), .rd_lvl(pal_lvl),
    .wr_ptr(wr_ptr), .flat(pal_flat)
  );

  gpm_unpack #(.DATA_W(DATA_W), .CODE_W(PTR_W)) u_unp (
    .byte_in(pix_byte), .mode(pix_mode), .idx(pix_idx),
    .code(code), .is_bw(is_bw), .bw_bit(bw_bit)
  );

  assign lvl_next = is_bw ? (bw_bit ? LVL_MAX : '0) : pal_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_out <= '0;
    else        gray_out <= lvl_next;
  end

endmodule

// File: rtl/gpm_checker.sv
module gpm_checker #(
  parameter int ENTRIES = 16,
  parameter int LVL_W   = 5,
  parameter int DATA_W  = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pal_wr,
  input logic                     ptr_clr,
  input logic [PTR_W-1:0]         wr_ptr,
  input logic [DATA_W-1:0]        cfg_wdata,
  input logic [ENTRIES*LVL_W-1:0] pal_flat,
  input logic [DATA_W-1:0]        pix_byte,
  input logic [1:0]               pix_mode,
  input logic [2:0]               pix_idx,
  input logic [LVL_W-1:0]         gray_out
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr && !ptr_clr && wr_ptr != LAST) |=> wr_ptr == $past(wr_ptr) + 1'b1);

  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr && !ptr_clr && wr_ptr == LAST) |=> wr_ptr == '0);

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> wr_ptr == '0);

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pal_wr && !ptr_clr) |=> $stable(wr_ptr));

  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr |=> pal_flat[$past(wr_ptr)*LVL_W +: LVL_W] == $past(cfg_wdata[LVL_W-1:0]));

  assert_bw_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_mode == 2'b00) |=> gray_out == ($past(pix_byte[pix_idx]) ? {LVL_W{1'b1}} : '0));

endmodule

bind gray_palette_mapper gpm_checker #(
  .ENTRIES(ENTRIES), .LVL_W(LVL_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pal_wr(pal_wr), .ptr_clr(ptr_clr),
  .wr_ptr(wr_ptr), .cfg_wdata(cfg_wdata), .pal_flat(pal_flat),
  .pix_byte(pix_byte), .pix_mode(pix_mode), .pix_idx(pix_idx),
  .gray_out(gray_out)
);

// File: tb/sim_gray_palette_mapper.sv
`timescale 1ns/1ps
module sim_gray_palette_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic [7:0] pix_byte = '0;
  logic [1:0] pix_mode = 2'b10;
  logic [2:0] pix_idx = '0;
  logic [4:0] gray_out;

  int n_chk = 0;
  int n_bad = 0;
  int mdl [16];
  int ptr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gray_palette_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .pix_byte(pix_byte),
    .pix_mode(pix_mode), .pix_idx(pix_idx), .gray_out(gray_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // palette write; the bench model follows the requirements
  task automatic pal_write(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[ptr] = d & 8'h1F;
    ptr = (ptr + 1) % 16;
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!d[5]) ptr = 0;
  endtask

  // drive lookup at a falling edge, sample after the next rising edge
  task automatic lookup(input logic [1:0] m, input logic [7:0] b,
                        input logic [2:0] i, output int lvl);
    @(negedge clk);
    pix_mode = m; pix_byte = b; pix_idx = i;
    @(posedge clk); #1;
    lvl = gray_out;
  endtask

  task automatic entry_of(input int e, output int lvl);
    lookup(2'b10, 8'(e), 3'd0, lvl);
  endtask

  task automatic t_reset;
    int v;
    check("R1 ctrl", ctrl_rdata, 0);
    check("R1 out", gray_out, 0);
    for (int e = 0; e < 16; e++) begin
      entry_of(e, v);
      check($sformatf("R1 entry%0d", e), v, 2 * e);
      mdl[e] = 2 * e;
    end
  endtask

  task automatic t_fill_and_wrap;
    int v;
    for (int e = 0; e < 16; e++) pal_write(8'hE0 | 8'((e * 3 + 1) & 31));
    for (int e = 0; e < 16; e++) begin
      entry_of(e, v);
      check($sformatf("R2/R6 entry%0d", e), v, (e * 3 + 1) & 31);
    end
    pal_write(8'h07);
    entry_of(0, v);  check("R3 wrap entry0", v, 7);
    entry_of(15, v); check("R3 entry15 kept", v, mdl[15]);
    entry_of(1, v);  check("R3 entry1 kept", v, mdl[1]);
  endtask

  task automatic t_ptr_restart;
    int v;
    pal_write(8'h11);              // entry 1
    ctrl_write(8'h20);             // bit5 set: pointer stays at 2
    pal_write(8'h12);
    entry_of(2, v); check("R4 bit5 set keeps pointer", v, 8'h12);
    entry_of(0, v); check("R4 entry0 untouched", v, 7);
    ctrl_write(8'h00);
    pal_write(8'h13);
    entry_of(0, v); check("R4 restart to entry0", v, 8'h13);
    entry_of(3, v); check("R4 entry3 untouched", v, mdl[3]);
    ctrl_write(8'hA5);
    check("R5 readback A5", ctrl_rdata, 8'hA5);
    ctrl_write(8'h5A);
    check("R5 readback 5A", ctrl_rdata, 8'h5A);
  endtask

  task automatic t_gray16;
    int v;
    lookup(2'b10, 8'h3C, 3'd0, v); check("R7 low nibble", v, mdl[12]);
    lookup(2'b10, 8'h3C, 3'd1, v); check("R7 high nibble", v, mdl[3]);
    lookup(2'b10, 8'h3C, 3'd6, v); check("R7 idx upper ignored", v, mdl[12]);
    lookup(2'b11, 8'h3C, 3'd1, v); check("R11 mode3 high", v, mdl[3]);
    lookup(2'b11, 8'h3C, 3'd4, v); check("R11 mode3 low", v, mdl[12]);
  endtask

  task automatic t_gray4;
    int v;
    for (int k = 0; k < 4; k++) begin
      lookup(2'b01, 8'hE4, 3'(k), v);
      check($sformatf("R8 pair%0d", k), v, mdl[k]);
    end
    lookup(2'b01, 8'hE4, 3'd5, v); check("R8 idx2 ignored", v, mdl[1]);
    lookup(2'b01, 8'hFF, 3'd3, v); check("R8 max code entry3", v, mdl[3]);
  endtask

  task automatic t_bw;
    int v;
    for (int k = 0; k < 8; k++) begin
      lookup(2'b00, 8'hA5, 3'(k), v);
      check($sformatf("R9 bit%0d", k), v, ((8'hA5 >> k) & 1) ? 31 : 0);
    end
  endtask

  task automatic t_same_cycle;
    int old0;
    ctrl_write(8'h00);
    old0 = mdl[0];
    @(negedge clk);
    pix_mode = 2'b10; pix_byte = 8'h00; pix_idx = 3'd0;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h1D;
    @(posedge clk); #1;
    check("R10 old value on same-cycle write", gray_out, old0);
    @(negedge clk);
    cfg_we = 1'b0;
    mdl[0] = 8'h1D; ptr = 1;
    @(posedge clk); #1;
    check("R10 new value next cycle", gray_out, 8'h1D);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_and_wrap();
    t_ptr_restart();
    t_gray16();
    t_gray4();
    t_bw();
    t_same_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule